// File: doc/BRIEF.md
# Keyed Unlock Guard for Privileged Register Writes

This block sits beside a register bank and decides whether privileged writes and privileged commands may go ahead. Software opens the guard by writing one fixed 32-bit unlock value, 0xF123F456, to a dedicated key address. While the guard is open, writes to a small set of protected control registers raise that register's write enable, and commands that need the key are passed on. The guard stays open across any number of further accesses. It closes again when any command starts, or when software writes some other value to the key address.

Writes to a protected register while the guard is closed are dropped and set a sticky violation flag. A key-required command issued while closed does not start and sets a sticky command-error flag. Both flags are visible through a status address and are cleared by writing ones to them. The register bus is a plain single-cycle strobe interface. Every write is taken in the cycle its strobe is high and there is no back-pressure, so the block has no valid/ready handshake. The command decode and the work each command does are outside this block. The block only qualifies the command strobe and pulses `cmd_start`.

Top module: `key_unlock_guard`

## Requirements
- R1: After reset the guard is closed, both sticky flags are 0, no write enable or command start is active, and every readable address returns 0.
- R2: A bus write of 0xF123F456 to the key address (default 0x00) opens the guard from the next clock cycle, and `unlocked` reads 1.
- R3: Once open, the guard stays open across any number of bus reads, protected-register writes, status writes and writes to unmapped addresses.
- R4: A bus write to the key address with any value other than 0xF123F456 closes the guard from the next cycle.
- R5: Every cycle in which `cmd_start` is 1 closes the guard from the next cycle.
- R6: While open, a bus write to address PROT_BASE+i (default 0x10+i) raises only `prot_we[i]`, in the same cycle as the write strobe.
- R7: While closed, a bus write to a protected address raises no `prot_we` bit and sets the sticky violation flag from the next cycle.
- R8: A command whose code has its bit set in KEYED_MASK (default codes 4 to 7) does not start while the guard is closed. It sets the sticky command-error flag from the next cycle, and the guard stays closed.
- R9: A command whose code is not key-required starts in the same cycle whatever the guard state. A key-required command starts in the same cycle when the guard is open.
- R10: The status address (default 0x04) reads bit 0 = violation, bit 1 = command error, bit 2 = `unlocked`. Writing it with bit 0 set clears the violation flag, and writing it with bit 1 set clears the command-error flag. Each clear acts only on its own flag.
- R11: The key address always reads back 0, including while the guard is open.
- R12: If a key write and a starting command fall in the same cycle, the guard is closed in the next cycle, even when the key value is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address (combinational read) |
| rd_data | output | DATA_W | Read data |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | CMD_W | Command code |
| cmd_start | output | 1 | Qualified command start pulse |
| unlocked | output | 1 | Guard open |
| prot_we | output | NUM_PROT | Per-target write enables |
| viol_flag | output | 1 | Sticky locked-write violation |
| cmd_err_flag | output | 1 | Sticky rejected-command error |

## Verification
The hardest case to reach from the ports is a key write and a starting command in the same cycle, because software would normally never issue both together. The bench drives `bus_wr` with the correct key and `cmd_wr` with a non-keyed code in one cycle, and checks that the guard ends up closed. The bench also covers persistence. It opens the guard once, then walks every protected target, reads, status writes and an unmapped write, checking `unlocked` after each access, so that a design that closes on the wrong event shows up.

// File: rtl/key_unlock_pkg.sv
package key_unlock_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hF123F456;

  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_OPEN   = 1'b1
  } lock_state_e;

  typedef struct packed {
    logic cmd_err;
    logic viol;
  } sticky_t;
endpackage

// File: rtl/ukey_state.sv
module ukey_state
  import key_unlock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              cmd_go,
  output logic              is_open
);
  localparam logic [DATA_W-1:0] KEY_VAL = DATA_W'(UNLOCK_KEY);

  lock_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LOCKED;
    end else if (cmd_go) begin
      state_q <= ST_LOCKED;
    end else if (key_wr) begin
      state_q <= (key_data == KEY_VAL) ? ST_OPEN : ST_LOCKED;
    end
  end

  assign is_open = (state_q == ST_OPEN);
endmodule

// File: rtl/ukey_gate.sv
module ukey_gate #(
  parameter int                ADDR_W    = 8,
  parameter int                NUM_PROT  = 4,
  parameter logic [ADDR_W-1:0] PROT_BASE = 8'h10
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                is_open,
  output logic [NUM_PROT-1:0] we,
  output logic                locked_hit
);
  logic [NUM_PROT-1:0] hit;

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_tgt
    localparam logic [ADDR_W-1:0] TGT = PROT_BASE + ADDR_W'(i);
    assign hit[i] = (bus_addr == TGT);
    assign we[i]  = bus_wr & hit[i] & is_open;
  end

  assign locked_hit = bus_wr & (|hit) & ~is_open;
endmodule

// File: rtl/ukey_cmd.sv
module ukey_cmd #(
  parameter int CMD_W = 4,
  parameter logic [(1<<CMD_W)-1:0] KEYED_MASK = '0
) (
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             is_open,
  output logic             start,
  output logic             reject
);
  logic keyed;

  assign keyed  = KEYED_MASK[cmd_code];
  assign start  = cmd_wr & (~keyed | is_open);
  assign reject = cmd_wr & keyed & ~is_open;
endmodule

// File: rtl/ukey_flags.sv
module ukey_flags
  import key_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       viol_set,
  input  logic       err_set,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  output sticky_t    flags
);
  sticky_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (viol_set)                     flags_q.viol <= 1'b1;
      else if (clr_wr && clr_bits[0])   flags_q.viol <= 1'b0;
      if (err_set)                      flags_q.cmd_err <= 1'b1;
      else if (clr_wr && clr_bits[1])   flags_q.cmd_err <= 1'b0;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/key_unlock_guard.sv
module key_unlock_guard
  import key_unlock_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                NUM_PROT   = 4,
  parameter int                CMD_W      = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h00,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h04,
  parameter logic [ADDR_W-1:0] PROT_BASE  = 8'h10,
  parameter logic [(1<<CMD_W)-1:0] KEYED_MASK = 16'h00F0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_code,
  output logic                cmd_start,
  output logic                unlocked,
  output logic [NUM_PROT-1:0] prot_we,
  output logic                viol_flag,
  output logic                cmd_err_flag
);
  localparam int STAT_BITS = 3;

  logic    key_wr, stat_wr, locked_hit, reject, is_open;
  sticky_t flags;

  assign key_wr  = bus_wr & (bus_addr == KEY_ADDR);
  assign stat_wr = bus_wr & (bus_addr == STAT_ADDR);

  ukey_state #(.DATA_W(DATA_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .cmd_go   (cmd_start),
    .is_open  (is_open)
  );

  ukey_gate #(.ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT), .PROT_BASE(PROT_BASE)) u_gate (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .is_open    (is_open),
    .we         (prot_we),
    .locked_hit (locked_hit)
  );

  ukey_cmd #(.CMD_W(CMD_W), .KEYED_MASK(KEYED_MASK)) u_cmd (
    .cmd_wr   (cmd_wr),
    .cmd_code (cmd_code),
    .is_open  (is_open),
    .start    (cmd_start),
    .reject   (reject)
  );

  ukey_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .viol_set (locked_hit),
    .err_set  (reject),
    .clr_wr   (stat_wr),
    .clr_bits (bus_wdata[1:0]),
    .flags    (flags)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_ADDR) begin
      rd_data[STAT_BITS-1:0] = {is_open, flags.cmd_err, flags.viol};
    end
  end

  assign unlocked     = is_open;
  assign viol_flag    = flags.viol;
  assign cmd_err_flag = flags.cmd_err;
endmodule

// File: rtl/key_unlock_guard_chk.sv
module key_unlock_guard_chk #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                NUM_PROT   = 4,
  parameter int                CMD_W      = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h00,
  parameter logic [ADDR_W-1:0] PROT_BASE  = 8'h10,
  parameter logic [(1<<CMD_W)-1:0] KEYED_MASK = 16'h00F0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [DATA_W-1:0]   rd_data,
  input logic                cmd_wr,
  input logic [CMD_W-1:0]    cmd_code,
  input logic                cmd_start,
  input logic                unlocked,
  input logic [NUM_PROT-1:0] prot_we,
  input logic                viol_flag
);
  localparam logic [DATA_W-1:0] KEY_VAL = DATA_W'(32'hF123F456);
  localparam logic [ADDR_W-1:0] PROT_TOP = PROT_BASE + ADDR_W'(NUM_PROT);

  logic prot_addr, key_ok, key_bad;
  assign prot_addr = (bus_addr >= PROT_BASE) && (bus_addr < PROT_TOP);
  assign key_ok    = bus_wr && (bus_addr == KEY_ADDR) && (bus_wdata == KEY_VAL);
  assign key_bad   = bus_wr && (bus_addr == KEY_ADDR) && (bus_wdata != KEY_VAL);

  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok && !cmd_start |=> unlocked);

  p_bad_key_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> !unlocked);

  p_start_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !unlocked);

  p_we_needs_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|prot_we) |-> unlocked);

  p_we_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prot_we));

  p_locked_write_viol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && prot_addr && !unlocked |=> viol_flag);

  p_keyed_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && KEYED_MASK[cmd_code] && !unlocked |-> !cmd_start);

  p_plain_cmd_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !KEYED_MASK[cmd_code] |-> cmd_start);

  p_key_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == KEY_ADDR |-> rd_data == '0);

  p_open_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked && !cmd_start && !(bus_wr && bus_addr == KEY_ADDR) |=> unlocked);
endmodule

bind key_unlock_guard key_unlock_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT), .CMD_W(CMD_W),
  .KEY_ADDR(KEY_ADDR), .PROT_BASE(PROT_BASE), .KEYED_MASK(KEYED_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
  .cmd_wr(cmd_wr), .cmd_code(cmd_code), .cmd_start(cmd_start),
  .unlocked(unlocked), .prot_we(prot_we), .viol_flag(viol_flag)
);

// File: tb/key_unlock_guard_test.sv
module key_unlock_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hF123F456;
  localparam logic [7:0] A_KEY = 8'h00, A_STAT = 8'h04, A_PROT = 8'h10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0, cmd_wr = 1'b0;
  logic [7:0]  bus_addr = '0, rd_addr = 8'h80;
  logic [31:0] bus_wdata = '0, rd_data;
  logic [3:0]  cmd_code = '0, prot_we;
  logic        cmd_start, unlocked, viol_flag, cmd_err_flag;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_unlock_guard uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code), .cmd_start(cmd_start),
    .unlocked(unlocked), .prot_we(prot_we), .viol_flag(viol_flag),
    .cmd_err_flag(cmd_err_flag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one write for a cycle; comb checks happen while it is held
  task automatic put_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic put_cmd(logic [3:0] c);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_code = c;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; cmd_wr = 1'b0;
    #1;
  endtask

  task automatic read_stat(output logic [31:0] v);
    rd_addr = A_STAT; #1; v = rd_data; rd_addr = 8'h80;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    check("R1 unlocked", unlocked, 0);
    check("R1 viol", viol_flag, 0);
    check("R1 cmd_err", cmd_err_flag, 0);
    check("R1 prot_we", prot_we, 0);
    check("R1 cmd_start", cmd_start, 0);
    read_stat(s);
    check("R1 status", s, 0);
    rd_addr = A_KEY; #1;
    check("R1 key read", rd_data, 0);
    rd_addr = 8'h80;
  endtask

  task automatic t_unlock();
    put_wr(A_KEY, KEY); idle();
    check("R2 open after key", unlocked, 1);
    rd_addr = A_KEY; #1;
    check("R11 key read while open", rd_data, 0);
    rd_addr = 8'h80;
  endtask

  task automatic t_persist();
    logic [31:0] s;
    for (int i = 0; i < 4; i++) begin
      put_wr(A_PROT + 8'(i), 32'h55);
      check("R6 target we", prot_we, 32'(1 << i));
      idle();
      check("R3 open after prot write", unlocked, 1);
    end
    put_wr(8'h7E, 32'h1234); idle();
    check("R3 open after unmapped write", unlocked, 1);
    put_wr(A_STAT, 32'h3); idle();
    check("R3 open after status write", unlocked, 1);
    read_stat(s);
    check("R10 status open bit", s, 32'h4);
    check("R7 no viol while open", viol_flag, 0);
  endtask

  task automatic t_wrong_key();
    put_wr(A_KEY, KEY ^ 32'h1); idle();
    check("R4 closed after wrong key", unlocked, 0);
  endtask

  task automatic t_locked_write();
    logic [31:0] s;
    put_wr(A_PROT + 8'd2, 32'hAA);
    check("R7 no we when locked", prot_we, 0);
    idle();
    check("R7 viol set", viol_flag, 1);
    put_wr(A_STAT, 32'h2); idle();
    check("R10 bit1 leaves viol", viol_flag, 1);
    read_stat(s);
    check("R10 status viol", s, 32'h1);
    put_wr(A_STAT, 32'h1); idle();
    check("R10 viol cleared", viol_flag, 0);
  endtask

  task automatic t_commands();
    logic [31:0] s;
    put_cmd(4'd5);
    check("R8 keyed blocked", cmd_start, 0);
    idle();
    check("R8 cmd_err set", cmd_err_flag, 1);
    check("R8 stays closed", unlocked, 0);
    put_cmd(4'd1);
    check("R9 plain cmd starts locked", cmd_start, 1);
    idle();
    put_wr(A_KEY, KEY); idle();
    check("R2 reopen", unlocked, 1);
    put_cmd(4'd6);
    check("R9 keyed starts when open", cmd_start, 1);
    idle();
    check("R5 closed after command", unlocked, 0);
    put_wr(A_KEY, KEY); idle();
    put_cmd(4'd2);
    check("R9 plain cmd starts open", cmd_start, 1);
    idle();
    check("R5 plain cmd closes", unlocked, 0);
    read_stat(s);
    check("R10 status err", s, 32'h2);
    put_wr(A_STAT, 32'h2); idle();
    check("R10 err cleared", cmd_err_flag, 0);
  endtask

  task automatic t_collide();
    put_wr(A_KEY, KEY); idle();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_KEY; bus_wdata = KEY;
    cmd_wr = 1'b1; cmd_code = 4'd3;
    #1;
    check("R12 cmd starts in collision", cmd_start, 1);
    idle();
    check("R12 closed after collision", unlocked, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_unlock();
    t_persist();
    t_wrong_key();
    t_locked_write();
    t_commands();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule